// File: doc/BRIEF.md
# Periodic Real-Time Wakeup Interrupt Timer

This block raises a periodic wakeup request from one of two slow tick sources. Both ticks arrive as single-cycle enables in the system clock domain. One is a nominal 1 kHz internal tick. The other is a reference tick from an external clock. A prescaler counts the selected tick. When it reaches the terminal count picked by a 3-bit period code, a sticky timeout flag is set and the prescaler wraps to zero. The timer keeps running after each timeout.

Software controls the block through one 8-bit control and status register. The register holds the timeout flag, a write-one acknowledge, the source select, an interrupt enable and the period code. The request output is high whenever the flag is set and the enable bit is 1. Changing the source or the period code restarts the prescaler, so the first period after a change is a full one.

Top module: `rtiWakeTimer`

## Requirements
- R1: After reset, `rdData` reads 8'h00 and `irq` is 0.
- R2: Register fields: bit 7 is the timeout flag and is read-only. Bit 6 is the acknowledge. Bit 5 selects the source (0 = internal tick, 1 = external tick). Bit 4 is the interrupt enable. Bits 2:0 are the period code. Bits 5, 4 and 2:0 read back exactly as last written.
- R3: Bit 3 and bit 6 always read 0. A 1 written to bit 3 is not stored.
- R4: Writing 1 to bit 6 clears the flag. Writing 0 to bit 6 leaves the flag unchanged. Writing 1 to bit 7 never sets the flag.
- R5: Period code 3'b000 stops the timer for either source. No number of ticks sets the flag.
- R6: With the internal source, codes 1 through 7 set the flag on the 8th, 32nd, 64th, 128th, 256th, 512th and 1024th counted tick respectively, and not before.
- R7: With the external source, codes 1 through 7 set the flag on the 256th, 1024th, 2048th, 4096th, 8192nd, 16384th and 32768th counted tick respectively, and not before.
- R8: Only the tick of the selected source advances the prescaler. The other tick has no effect.
- R9: `irq` is 1 exactly when the flag is 1 and the enable bit is 1.
- R10: A write that changes the source bit or the period code clears the prescaler, so a full new period follows. A write that changes neither leaves the prescaler running.
- R11: The flag stays set through later timeouts until it is acknowledged. When a timeout and an acknowledge fall in the same cycle, the flag ends up set.
- R12: The prescaler wraps to zero on each timeout and keeps counting, so the next timeout comes after exactly one more period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset, asynchronous assert |
| tickInt | input | 1 | Internal 1 kHz tick, one-cycle enable |
| tickExt | input | 1 | External reference tick, one-cycle enable |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read value |
| irq | output | 1 | Wakeup interrupt request |

## Verification
A vector table walks all fourteen source/code pairs with only the selected tick driven, one tick per cycle. Each pair is checked one tick short of its period and again at the period itself, which tells apart off-by-one terminal counts, swapped table entries and a wrong source mapping. Directed sequences then follow:
- The unselected tick is driven alone, which shows a wrong source mux.
- Ticks are run with code zero, which shows a timer that should be stopped but still runs.
- The configuration is changed partway through a period, which separates a restarted prescaler from a stale one.
- A timeout and an acknowledge are made to land in the same cycle, which shows which of the two wins.

// File: rtl/rtiPkg.sv
package rtiPkg;

  localparam int REG_W    = 8;
  localparam int FLAG_BIT = 7;
  localparam int ACK_BIT  = 6;
  localparam int SRC_BIT  = 5;
  localparam int IE_BIT   = 4;
  localparam int RSVD_BIT = 3;
  localparam int SEL_LSB  = 0;
  localparam int SEL_W    = 3;

  // Strobes and settings passed from the control to the datapath
  typedef struct packed {
    logic             clrCnt;   // restart prescaler this cycle
    logic             extSrc;   // 1: count external tick
    logic [SEL_W-1:0] selCode;  // period code, 0 = stopped
  } ctrlStrobes_t;

endpackage

// File: rtl/rtiDatapath.sv
module rtiDatapath
  import rtiPkg::*;
#(
  parameter int INT_MIN_LOG2 = 3,
  parameter int EXT_MIN_LOG2 = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tickInt,
  input  logic         tickExt,
  input  ctrlStrobes_t strobes,
  output logic         timeout
);

  localparam int NUM_CODES = 1 << SEL_W;
  localparam int MAX_BASE  = (INT_MIN_LOG2 > EXT_MIN_LOG2) ? INT_MIN_LOG2 : EXT_MIN_LOG2;
  localparam int CNT_W     = MAX_BASE + NUM_CODES - 1;

  // Code 1 gives 2^base. Code k >= 2 gives 2^(base+k). The result is the count minus one.
  function automatic logic [CNT_W-1:0] termFor(input int baseLog2, input int code);
    int sh;
    sh = (code == 1) ? baseLog2 : baseLog2 + code;
    return CNT_W'((64'd1 << sh) - 64'd1);
  endfunction

  logic [CNT_W-1:0] termIntTab [NUM_CODES];
  logic [CNT_W-1:0] termExtTab [NUM_CODES];

  for (genvar c = 0; c < NUM_CODES; c++) begin : g_term
    if (c == 0) begin : g_off
      assign termIntTab[c] = '0;
      assign termExtTab[c] = '0;
    end else begin : g_on
      assign termIntTab[c] = termFor(INT_MIN_LOG2, c);
      assign termExtTab[c] = termFor(EXT_MIN_LOG2, c);
    end
  end

  logic             enable;
  logic             tickSel;
  logic             atTerm;
  logic [CNT_W-1:0] termNow;
  logic [CNT_W-1:0] cntQ;

  always_comb begin
    enable  = |strobes.selCode;
    tickSel = strobes.extSrc ? tickExt : tickInt;
    termNow = strobes.extSrc ? termExtTab[strobes.selCode] : termIntTab[strobes.selCode];
    atTerm  = (cntQ == termNow);
    timeout = enable && tickSel && atTerm && !strobes.clrCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strobes.clrCnt || !enable) begin
      cntQ <= '0;
    end else if (tickSel) begin
      cntQ <= atTerm ? '0 : cntQ + 1'b1;
    end
  end

  // R12
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    enable |-> (cntQ <= termNow));

  // R5
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (cntQ == '0));

  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrCnt |=> (cntQ == '0));

endmodule

// File: rtl/rtiCtrl.sv
module rtiCtrl
  import rtiPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             timeout,
  output ctrlStrobes_t     strobes,
  output logic [REG_W-1:0] rdData,
  output logic             irq
);

  logic             flagQ;
  logic             ieQ;
  logic             srcQ;
  logic [SEL_W-1:0] selQ;
  logic             ackWr;
  logic             cfgChange;
  logic             unusedWrBits;

  assign unusedWrBits = ^{wrData[FLAG_BIT], wrData[RSVD_BIT]};

  always_comb begin
    ackWr     = wrEn && wrData[ACK_BIT];
    cfgChange = wrEn && ((wrData[SRC_BIT] != srcQ) ||
                         (wrData[SEL_LSB +: SEL_W] != selQ));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ieQ  <= 1'b0;
      srcQ <= 1'b0;
      selQ <= '0;
    end else if (wrEn) begin
      ieQ  <= wrData[IE_BIT];
      srcQ <= wrData[SRC_BIT];
      selQ <= wrData[SEL_LSB +: SEL_W];
    end
  end

  // A timeout has priority over an acknowledge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        flagQ <= 1'b0;
    else if (timeout) flagQ <= 1'b1;
    else if (ackWr)   flagQ <= 1'b0;
  end

  always_comb begin
    strobes.clrCnt  = cfgChange;
    strobes.extSrc  = srcQ;
    strobes.selCode = selQ;
    rdData                     = '0;
    rdData[FLAG_BIT]           = flagQ;
    rdData[SRC_BIT]            = srcQ;
    rdData[IE_BIT]             = ieQ;
    rdData[SEL_LSB +: SEL_W]   = selQ;
    irq                        = flagQ && ieQ;
  end

  // R11
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    timeout |=> flagQ);

  // R4
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackWr && !timeout) |=> !flagQ);

  // R4
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!timeout && !ackWr) |=> $stable(flagQ));

endmodule

// File: rtl/rtiWakeTimer.sv
module rtiWakeTimer
  import rtiPkg::*;
#(
  parameter int INT_MIN_LOG2 = 3,
  parameter int EXT_MIN_LOG2 = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickInt,
  input  logic       tickExt,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       irq
);

  ctrlStrobes_t strobes;
  logic         timeout;

  rtiCtrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .timeout (timeout),
    .strobes (strobes),
    .rdData  (rdData),
    .irq     (irq)
  );

  rtiDatapath #(
    .INT_MIN_LOG2 (INT_MIN_LOG2),
    .EXT_MIN_LOG2 (EXT_MIN_LOG2)
  ) uDatapath (
    .clk     (clk),
    .rstN    (rstN),
    .tickInt (tickInt),
    .tickExt (tickExt),
    .strobes (strobes),
    .timeout (timeout)
  );

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (rdData[FLAG_BIT] && rdData[IE_BIT]));

  // R3
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[ACK_BIT] == 1'b0) && (rdData[RSVD_BIT] == 1'b0));

endmodule

// File: tb/tb_rtiWakeTimer.sv
module tb_rtiWakeTimer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickInt = 1'b0;
  logic       tickExt = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       irq;

  int  nChecks = 0;
  int  nFail = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  rtiWakeTimer dut (
    .clk(clk), .rstN(rstN), .tickInt(tickInt), .tickExt(tickExt),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  // {source, code, period in ticks}
  localparam logic [19:0] VEC [14] = '{
    {1'b0, 3'd1, 16'd8},    {1'b0, 3'd2, 16'd32},   {1'b0, 3'd3, 16'd64},
    {1'b0, 3'd4, 16'd128},  {1'b0, 3'd5, 16'd256},  {1'b0, 3'd6, 16'd512},
    {1'b0, 3'd7, 16'd1024},
    {1'b1, 3'd1, 16'd256},  {1'b1, 3'd2, 16'd1024}, {1'b1, 3'd3, 16'd2048},
    {1'b1, 3'd4, 16'd4096}, {1'b1, 3'd5, 16'd8192}, {1'b1, 3'd6, 16'd16384},
    {1'b1, 3'd7, 16'd32768}
  };

  logic       vExt;
  logic [2:0] vCode;
  int         vPer;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Hold the chosen tick high for n cycles, then return at a falling edge
  task automatic runTicks(input int n, input logic ext);
    if (n > 0) begin
      @(negedge clk);
      if (ext) tickExt = 1'b1; else tickInt = 1'b1;
      repeat (n) @(posedge clk);
      @(negedge clk);
      tickExt = 1'b0;
      tickInt = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(rdData == 8'h00, "R1 reset register", rdData, 8'h00);
    check(irq == 1'b0, "R1 reset irq", irq, 0);

    // Table: every source and code, one tick short, then exactly at the period
    for (int i = 0; i < 14; i++) begin
      vExt  = VEC[i][19];
      vCode = VEC[i][18:16];
      vPer  = int'(VEC[i][15:0]);
      writeReg({1'b0, 1'b1, vExt, 1'b1, 1'b0, vCode});
      runTicks(vPer - 1, vExt);
      check(rdData[7] == 1'b0, vExt ? "R7 early flag" : "R6 early flag", rdData, vPer);
      runTicks(1, vExt);
      check(rdData[7] == 1'b1 && irq, vExt ? "R7 flag at period" : "R6 flag at period",
            rdData, vPer);
    end

    // R12 wrap: internal code 1
    writeReg(8'h51);
    runTicks(8, 1'b0);
    check(rdData[7] == 1'b1, "R12 first timeout", rdData, 8'h91);
    writeReg(8'h51);
    runTicks(7, 1'b0);
    check(rdData[7] == 1'b0, "R12 no early wrap timeout", rdData, 8'h11);
    runTicks(1, 1'b0);
    check(rdData[7] == 1'b1, "R12 second timeout", rdData, 8'h91);

    // R11 sticky across ticks, then R4 acknowledge
    runTicks(3, 1'b0);
    check(rdData[7] == 1'b1, "R11 flag sticky", rdData, 8'h91);
    writeReg(8'h51);
    check(rdData == 8'h11, "R4 ack clears flag", rdData, 8'h11);
    runTicks(4, 1'b0);
    check(rdData[7] == 1'b0, "R10 same-config write keeps count", rdData, 8'h11);
    // Eighth tick and acknowledge in the same cycle
    @(negedge clk);
    tickInt = 1'b1;
    wrEn = 1'b1;
    wrData = 8'h51;
    @(negedge clk);
    tickInt = 1'b0;
    wrEn = 1'b0;
    check(rdData[7] == 1'b1, "R11 timeout beats ack", rdData, 8'h91);

    // R4 ack 0 no effect, bit 7 write cannot set
    writeReg(8'h11);
    check(rdData == 8'h91, "R4 ack0 keeps flag", rdData, 8'h91);
    writeReg(8'h51);
    writeReg(8'h91);
    check(rdData == 8'h11, "R4 bit7 write ignored", rdData, 8'h11);

    // R9 enable gating
    writeReg(8'h01);
    runTicks(8, 1'b0);
    check(rdData == 8'h81 && irq == 1'b0, "R9 irq masked", {irq, rdData}, 8'h81);
    writeReg(8'h11);
    check(irq == 1'b1, "R9 irq asserted", irq, 1);
    writeReg(8'h51);
    check(irq == 1'b0, "R9 irq drops on ack", irq, 0);

    // R2 / R3 field readback
    writeReg(8'hFF);
    check(rdData == 8'h37, "R3 reserved and ack read zero", rdData, 8'h37);
    writeReg(8'h2A);
    check(rdData == 8'h22, "R2 fields read back", rdData, 8'h22);

    // R8 source selection
    writeReg(8'h41);
    runTicks(50, 1'b1);
    check(rdData[7] == 1'b0, "R8 ext tick ignored on internal", rdData, 8'h01);
    writeReg(8'h61);
    runTicks(300, 1'b0);
    check(rdData[7] == 1'b0, "R8 int tick ignored on external", rdData, 8'h21);
    runTicks(256, 1'b1);
    check(rdData[7] == 1'b1, "R8 ext tick counted", rdData, 8'hA1);

    // R10 restart on period change
    writeReg(8'h41);
    runTicks(5, 1'b0);
    writeReg(8'h42);
    runTicks(31, 1'b0);
    check(rdData[7] == 1'b0, "R10 full period after change", rdData, 8'h02);
    runTicks(1, 1'b0);
    check(rdData[7] == 1'b1, "R10 timeout after full period", rdData, 8'h82);
    // R10 restart on source change
    writeReg(8'h62);
    runTicks(1000, 1'b1);
    writeReg(8'h42);
    runTicks(31, 1'b0);
    check(rdData[7] == 1'b0, "R10 source change restarts", rdData, 8'h02);

    // R5 code zero stops the timer
    writeReg(8'h50);
    runTicks(2000, 1'b0);
    check(rdData[7] == 1'b0 && irq == 1'b0, "R5 internal stopped", rdData, 8'h10);
    writeReg(8'h70);
    runTicks(1000, 1'b1);
    check(rdData[7] == 1'b0, "R5 external stopped", rdData, 8'h30);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired (all R) actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule